// File: doc/BRIEF.md
# Half-Cycle Synchronous Bus Read System

This block models one controller and a set of memory-mapped device interfaces on a shared synchronous bus. Only reads are modelled. On each rising clock edge the controller launches a transfer by registering the requested address and a read flag onto the bus. The falling edge opens the peripheral half of the cycle. During that half a central decoder selects the one device whose window holds the address. The selected device looks up the addressed register and, for a read, enables its output onto the shared data bus.

The next rising edge ends the transfer. The controller copies the bus value into its memory data register on that edge, and the same edge removes every device output enable. No ready or completion line exists: the fixed edge is the only completion event. The shared bus is an OR of enable-qualified device outputs, so it reads as zero when no device drives it. An unmapped read therefore captures zero and raises a one-cycle flag.

Top module: `hcb_read_system`

## Requirements
- R1: While reset is held, and until the first rising edge after it is released, `bus_read`, `mdr`, `unmapped` and `dev_oe` are all zero.
- R2: The `issue_addr` and `issue_read` values present at a rising edge appear on `bus_addr` and `bus_read` right after that edge and stay there for the whole clock cycle.
- R3: Device d (0 to NUM_DEV-1) owns the REGS_PER_DEV addresses starting at BASE_ADDR + d*REGS_PER_DEV, with register k at offset k. By default these are 0x0400 to 0x040F, and the device index is address bits [3:2]. Register k of device d holds DATA_KEY ^ (d << 8) ^ (k * 0x0011), with DATA_KEY = 0x3C5A by default.
- R4: For a read cycle to a mapped address, `mdr` holds that register's R3 value right after the rising edge that ends the cycle, one clock after the address was put on the bus.
- R5: During the low half of a read cycle to device d, `dev_oe` has only bit d set.
- R6: During the high half of every cycle, `dev_oe` is all zeros: devices stop driving at the rising edge.
- R7: At most one bit of `dev_oe` is set at any time.
- R8: A cycle with `bus_read` low asserts no `dev_oe`, leaves `mdr` unchanged and leaves `unmapped` low after its closing edge.
- R9: A read cycle to an address outside every device window asserts no `dev_oe`. At its closing edge `mdr` becomes zero and `unmapped` goes high for exactly that one cycle.
- R10: `periph_phase` is 1 in the low half of the clock and 0 in the high half, from the first rising edge after reset onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the rising edge launches and ends transfers, the falling edge starts the peripheral half |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_addr | input | ADDR_W (16) | Address the controller puts on the bus at the next rising edge |
| issue_read | input | 1 | 1 for a read transfer, 0 for a non-read cycle |
| bus_addr | output | ADDR_W (16) | Address currently on the bus |
| bus_read | output | 1 | Read flag currently on the bus |
| periph_phase | output | 1 | High during the peripheral (clock-low) half |
| dev_oe | output | NUM_DEV (4) | Per-device output enables onto the data bus |
| mdr | output | DATA_W (16) | Memory data register |
| unmapped | output | 1 | Previous read cycle hit no device |

## Verification
The assertions assume a free-running clock with both edges present, because the peripheral half is tracked by flops on each edge. They also assume reset starts asserted and is released away from a falling edge, and that `issue_addr` and `issue_read` never change at a rising edge. The stimulus honours all of this by changing inputs only on falling edges and releasing reset a little after one. Addresses are drawn at random: mostly from inside the device windows, some from anywhere in the 16-bit space. Most cycles are reads. Directed cases add window edges, back-to-back reads of one device, unmapped reads straight after mapped ones, and non-read cycles placed between reads.

// File: rtl/hcb_pkg.sv
package hcb_pkg;

   typedef enum logic {
      PH_CTRL   = 1'b0,
      PH_PERIPH = 1'b1
   } hcb_phase_e;

   function automatic bit hcb_is_pow2(input int n);
      return (n > 1) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/hcb_controller.sv
module hcb_controller import hcb_pkg::*; #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] issue_addr,
   input  logic              issue_read,
   input  logic [DATA_W-1:0] rd_data,
   input  logic              hit,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              bus_read,
   output logic              periph,
   output logic [DATA_W-1:0] mdr,
   output logic              unmapped
);

   logic       tog_rise;
   logic       tog_fall;
   hcb_phase_e phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_addr <= '0;
         bus_read <= 1'b0;
         tog_rise <= 1'b0;
         mdr      <= '0;
         unmapped <= 1'b0;
      end else begin
         bus_addr <= issue_addr;
         bus_read <= issue_read;
         tog_rise <= ~tog_rise;
         if (bus_read) begin
            mdr      <= rd_data;
            unmapped <= ~hit;
         end else begin
            unmapped <= 1'b0;
         end
      end
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) tog_fall <= 1'b0;
      else        tog_fall <= tog_rise;
   end

   assign phase  = (tog_rise == tog_fall) ? PH_PERIPH : PH_CTRL;
   assign periph = (phase == PH_PERIPH);

   a_r8_mdr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_read |=> mdr == $past(mdr))
      else $error("R8: mdr changed after a non-read cycle");

   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> mdr == '0)
      else $error("R9: unmapped read left a nonzero mdr");

   a_r10_low_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
      periph)
      else $error("R10: peripheral phase not active before rising edge");

endmodule

// File: rtl/hcb_addr_decoder.sv
module hcb_addr_decoder #(
   parameter int                ADDR_W       = 16,
   parameter int                NUM_DEV      = 4,
   parameter int                REGS_PER_DEV = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR    = 16'h0400,
   localparam int               DEV_W        = $clog2(NUM_DEV),
   localparam int               REG_W        = $clog2(REGS_PER_DEV),
   localparam int               SPAN_W       = DEV_W + REG_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               periph,
   output logic               hit,
   output logic [NUM_DEV-1:0] sel,
   output logic [REG_W-1:0]   reg_idx
);

   logic [DEV_W-1:0] dev_idx;

   assign hit     = (bus_addr[ADDR_W-1:SPAN_W] == BASE_ADDR[ADDR_W-1:SPAN_W]);
   assign dev_idx = bus_addr[SPAN_W-1:REG_W];
   assign reg_idx = bus_addr[REG_W-1:0];

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_sel
      assign sel[d] = periph && hit && (dev_idx == DEV_W'(d));
   end

   a_r7_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel))
      else $error("R7: more than one device selected");

endmodule

// File: rtl/hcb_device.sv
module hcb_device #(
   parameter int                DATA_W       = 16,
   parameter int                REGS_PER_DEV = 4,
   parameter int                DEV_IDX      = 0,
   parameter logic [DATA_W-1:0] DATA_KEY     = 16'h3C5A,
   localparam int               REG_W        = $clog2(REGS_PER_DEV)
) (
   input  logic              sel,
   input  logic              periph,
   input  logic              bus_read,
   input  logic [REG_W-1:0]  reg_idx,
   output logic              oe,
   output logic [DATA_W-1:0] drive
);

   logic [DATA_W-1:0] regs [REGS_PER_DEV];
   logic [DATA_W-1:0] access;

   for (genvar k = 0; k < REGS_PER_DEV; k++) begin : g_reg
      assign regs[k] = DATA_KEY ^ DATA_W'(DEV_IDX * 256) ^ DATA_W'(k * 17);
   end

   // access step: the register lookup only yields data once selected
   assign access = sel ? regs[reg_idx] : '0;
   assign oe     = periph & sel & bus_read;
   assign drive  = oe ? access : '0;

endmodule

// File: rtl/hcb_bus_merge.sv
module hcb_bus_merge #(
   parameter int DATA_W  = 16,
   parameter int NUM_DEV = 4
) (
   input  logic [NUM_DEV-1:0][DATA_W-1:0] drive,
   output logic [DATA_W-1:0]              bus_data
);

   logic [NUM_DEV:0][DATA_W-1:0] chain;

   assign chain[0] = '0;
   for (genvar d = 0; d < NUM_DEV; d++) begin : g_or
      assign chain[d+1] = chain[d] | drive[d];
   end
   assign bus_data = chain[NUM_DEV];

endmodule

// File: rtl/hcb_read_system.sv
module hcb_read_system import hcb_pkg::*; #(
   parameter int                ADDR_W       = 16,
   parameter int                DATA_W       = 16,
   parameter int                NUM_DEV      = 4,
   parameter int                REGS_PER_DEV = 4,
   parameter logic [ADDR_W-1:0] BASE_ADDR    = 16'h0400,
   parameter logic [DATA_W-1:0] DATA_KEY     = 16'h3C5A
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  issue_addr,
   input  logic               issue_read,
   output logic [ADDR_W-1:0]  bus_addr,
   output logic               bus_read,
   output logic               periph_phase,
   output logic [NUM_DEV-1:0] dev_oe,
   output logic [DATA_W-1:0]  mdr,
   output logic               unmapped
);

   localparam int DEV_W  = $clog2(NUM_DEV);
   localparam int REG_W  = $clog2(REGS_PER_DEV);
   localparam int SPAN_W = DEV_W + REG_W;

   if (!hcb_is_pow2(NUM_DEV)) begin : g_chk_dev
      $error("NUM_DEV must be a power of two, at least 2");
   end
   if (!hcb_is_pow2(REGS_PER_DEV)) begin : g_chk_reg
      $error("REGS_PER_DEV must be a power of two, at least 2");
   end
   if (SPAN_W >= ADDR_W) begin : g_chk_span
      $error("device windows exceed the address space");
   end
   if (BASE_ADDR[SPAN_W-1:0] != '0) begin : g_chk_align
      $error("BASE_ADDR must be aligned to the whole window span");
   end
   if (DATA_W < 8 + DEV_W) begin : g_chk_data
      $error("DATA_W too narrow for register contents");
   end

   logic [NUM_DEV-1:0]              sel;
   logic [REG_W-1:0]                reg_idx;
   logic                            hit;
   logic [NUM_DEV-1:0][DATA_W-1:0]  drive;
   logic [DATA_W-1:0]               bus_data;

   hcb_controller #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
      .clk, .rst_n, .issue_addr, .issue_read,
      .rd_data(bus_data), .hit,
      .bus_addr, .bus_read, .periph(periph_phase), .mdr, .unmapped
   );

   hcb_addr_decoder #(
      .ADDR_W(ADDR_W), .NUM_DEV(NUM_DEV),
      .REGS_PER_DEV(REGS_PER_DEV), .BASE_ADDR(BASE_ADDR)
   ) dec_i (
      .clk, .rst_n, .bus_addr, .periph(periph_phase),
      .hit, .sel, .reg_idx
   );

   for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
      hcb_device #(
         .DATA_W(DATA_W), .REGS_PER_DEV(REGS_PER_DEV),
         .DEV_IDX(d), .DATA_KEY(DATA_KEY)
      ) dev_i (
         .sel(sel[d]), .periph(periph_phase), .bus_read,
         .reg_idx, .oe(dev_oe[d]), .drive(drive[d])
      );
   end

   hcb_bus_merge #(.DATA_W(DATA_W), .NUM_DEV(NUM_DEV)) merge_i (
      .drive, .bus_data
   );

   a_r7_oe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(dev_oe))
      else $error("R7: several output enables at once");

   a_r6_quiet_high: assert property (@(negedge clk) disable iff (!rst_n)
      !periph_phase |-> dev_oe == '0)
      else $error("R6: device driving during the high half");

   a_r5_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      (|dev_oe) |-> bus_read)
      else $error("R5: output enabled without a read");

   a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_read && (|dev_oe)) |=> mdr == $past(bus_data))
      else $error("R4: mdr does not hold the driven bus value");

endmodule

// File: tb/hcb_read_system_tb.sv
module hcb_read_system_tb_top;

   localparam logic [15:0] BASE = 16'h0400;
   localparam logic [15:0] KEY  = 16'h3C5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] issue_addr = '0;
   logic        issue_read = 1'b0;
   logic [15:0] bus_addr;
   logic        bus_read;
   logic        periph_phase;
   logic [3:0]  dev_oe;
   logic [15:0] mdr;
   logic        unmapped;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   logic [15:0] cur_a   = '0;
   logic        cur_r   = 1'b0;
   logic [15:0] exp_mdr = '0;

   always #5 clk = ~clk;

   hcb_read_system dut_i (
      .clk, .rst_n, .issue_addr, .issue_read,
      .bus_addr, .bus_read, .periph_phase, .dev_oe, .mdr, .unmapped
   );

   function automatic bit is_mapped(input logic [15:0] a);
      return a[15:4] == BASE[15:4];
   endfunction

   function automatic logic [15:0] ref_val(input logic [15:0] a);
      if (!is_mapped(a)) return 16'h0000;
      return KEY ^ (16'(a[3:2]) << 8) ^ (16'(a[1:0]) * 16'h0011);
   endfunction

   function automatic logic [3:0] ref_oe(input logic [15:0] a, input logic r);
      if (!r || !is_mapped(a)) return 4'b0000;
      return 4'b0001 << a[3:2];
   endfunction

   task automatic check(input string tag, input bit ok,
                        input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   task automatic step(input logic [15:0] a, input logic r);
      string tag;
      @(negedge clk);
      issue_addr = a;
      issue_read = r;
      #2;
      // low half of the cycle currently on the bus
      check(cur_r ? "R5" : "R8", dev_oe == ref_oe(cur_a, cur_r),
            16'(dev_oe), 16'(ref_oe(cur_a, cur_r)));
      check("R10", periph_phase == 1'b1, 16'(periph_phase), 16'd1);
      @(posedge clk);
      #2;
      if (cur_r) exp_mdr = ref_val(cur_a);
      tag = !cur_r ? "R8" : (is_mapped(cur_a) ? "R4" : "R9");
      check(tag, mdr == exp_mdr, mdr, exp_mdr);
      check(tag, unmapped == (cur_r && !is_mapped(cur_a)),
            16'(unmapped), 16'(cur_r && !is_mapped(cur_a)));
      check("R2", bus_addr == a && bus_read == r, bus_addr, a);
      check("R6", dev_oe == 4'b0000, 16'(dev_oe), 16'd0);
      check("R10", periph_phase == 1'b0, 16'(periph_phase), 16'd0);
      cur_a = a;
      cur_r = r;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      #1;
      // R1: reset state before the first rising edge
      check("R1", bus_read == 1'b0, 16'(bus_read), 16'd0);
      check("R1", mdr == 16'h0000, mdr, 16'h0000);
      check("R1", unmapped == 1'b0, 16'(unmapped), 16'd0);
      check("R1", dev_oe == 4'b0000, 16'(dev_oe), 16'd0);

      // directed: R3 window edges and every device
      step(16'h0400, 1'b1);
      step(16'h040F, 1'b1);
      step(16'h0405, 1'b1);
      step(16'h0405, 1'b1);
      step(16'h040A, 1'b1);
      // R9: just outside the windows, straight after a mapped read
      step(16'h03FF, 1'b1);
      step(16'h0410, 1'b1);
      step(16'h0403, 1'b1);
      // R8: non-read cycles to a mapped address between reads
      step(16'h0406, 1'b0);
      step(16'h0406, 1'b0);
      step(16'h0406, 1'b1);
      step(16'hFFFF, 1'b0);
      step(16'h0000, 1'b1);
      step(16'h040C, 1'b1);

      // constrained random mix
      for (int i = 0; i < 300; i++) begin
         logic [15:0] a;
         logic        r;
         if (($urandom % 10) < 7) a = BASE + 16'($urandom % 16);
         else                     a = 16'($urandom);
         r = (($urandom % 100) < 85);
         step(a, r);
      end
      step(16'h0401, 1'b1);
      step(16'h0401, 1'b0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule